// File: doc/BRIEF.md
# Task Configuration Record Loader

This block unpacks a task configuration record that sits in a word-addressed memory. After a start pulse it reads the record from a given base address. The leading length word sets how many configuration words go out on a valid/ready configuration-port stream. The block also latches the task's parameter pointer, its footprint in reconfigurable units, its execution time per unit of data and its reconfiguration kind.

A record marked for specialized (parameter-driven) reconfiguration carries an extension after the plain configuration words. The extension holds a parameter count, then one descriptor word per parameter naming a width and an exchange-register index, then a length word and that many parameterized configuration words. The loader reads each named exchange register into a parameter slot. The slots are on the ports before the first parameterized word is offered, so a downstream evaluator sees the values next to the words it specializes.

In the background, a sequential divider and multiplier estimate the task's run time in clock cycles. The estimate is the per-unit time multiplied by the number of data units the element count spans, with a partial unit counted as a whole one. A one-cycle done pulse ends every load, and an error flag marks a malformed record.

Top module: `tcl_loader`

## Requirements
- R1: Out of reset the block is idle: busy, done, err, cfg_valid, mem_rd_en and est_valid are all 0.
- R2: Record word layout, relative to the base address. Offset 0 is the configuration length L. Offset 1 is the parameter pointer. Offset 2 holds the width in bits [15:0] and the height in bits [31:16]. Offset 3 is the per-unit time. Offset 4 holds the kind in bit 0, where 1 means specialized. Each of these appears unchanged on its descriptor output once done pulses.
- R3: The L words at offsets 5 to 4+L go out on cfg_data in address order with cfg_param low. While cfg_ready is low, cfg_valid stays high and cfg_data stays unchanged.
- R4: A length word of zero ends the load with err high and one done pulse. No word is streamed and no estimate is started.
- R5: For kind 0 the load ends after the last configuration word is accepted. Nothing past offset 4+L is read.
- R6: For kind 1, the word at offset 5+L is the count N. It is followed by N descriptor words, each with width in bits [15:8] and exchange-register index in bits [7:0]. For each slot k, prm_width holds its width and prm_value holds the exchange register it names. prm_count equals N, and prm_count never exceeds 8.
- R7: A count above 8 ends the load with err high and one done pulse. No parameter is captured and no parameterized word is streamed.
- R8: After the descriptor words comes a length word P and then P parameterized words. These are streamed in order with cfg_param high, and the parameter slots are already filled when the first of them is offered.
- R9: est_cycles = per-unit time × ceil(elem_count / UNIT), with UNIT = 100 by default. est_valid rises when the value is ready, and est_valid is cleared by an accepted start.
- R10: A start pulse while busy is ignored and does not disturb the load in progress.
- R11: done is high for exactly one cycle per load, after the final word is accepted or the error is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load (taken only when idle) |
| base_addr | input | 8 | Record base address |
| elem_count | input | 32 | Data size in elements, latched at start |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 8 | Memory read address |
| mem_rdata | input | 32 | Read data, one cycle after the strobe |
| xreg_sel | output | 8 | Exchange-register index being read |
| xreg_data | input | 32 | Exchange-register value (combinational) |
| cfg_valid | output | 1 | Configuration word valid |
| cfg_ready | input | 1 | Configuration port accepts the word |
| cfg_data | output | 32 | Configuration word |
| cfg_param | output | 1 | Word is parameterized configuration |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle end-of-load pulse |
| err | output | 1 | Malformed record, held until next start |
| desc_param_ptr | output | 32 | Parameter pointer |
| desc_width | output | 16 | Task width in units |
| desc_height | output | 16 | Task height in units |
| desc_unit_time | output | 32 | Cycles per data unit |
| desc_micro | output | 1 | Specialized reconfiguration kind |
| prm_count | output | 4 | Number of parameters captured |
| prm_width | output | 64 | Slot k width at [8k+7:8k] |
| prm_value | output | 256 | Slot k value at [32k+31:32k] |
| est_valid | output | 1 | Cycle estimate ready |
| est_cycles | output | 64 | Estimated execution cycles |

## Verification
Records of both kinds are loaded. Plain records of different lengths tell apart an off-by-one in the length bound and a read past the end. Specialized records with zero, three and the full eight parameters, and with zero or several parameterized words, separate slot-indexing faults from count handling. The element counts are chosen to show whether the ceiling rounding is done: exactly one unit, a unit plus one element, a fraction of a unit, and zero. Irregular ready patterns, a zero length, a count of nine and a second start in mid-load probe stalls, both error exits and start filtering.

// File: rtl/tcl_pkg.sv
// Shared types for the task configuration record loader.
// Assumes: nothing beyond IEEE 1800-2017.
package tcl_pkg;

    // Sequencer control states
    typedef enum logic [2:0] {
        S_IDLE, S_RD, S_WT, S_SEND, S_GATH, S_DONE
    } ld_state_t;

    // Which record field the next returned word belongs to
    typedef enum logic [3:0] {
        P_LEN, P_PTR, P_SIZE, P_TIME, P_KIND, P_CFG,
        P_NUM, P_PAIR, P_PLEN, P_PCFG
    } ld_phase_t;

    // Estimator states
    typedef enum logic [1:0] {
        E_IDLE, E_DIV, E_FIX, E_MUL
    } est_state_t;

endpackage

// File: rtl/tcl_est.sv
// Execution-time estimator: cycles = utime * ceil(elem / UNIT).
// A restoring divider (DW steps) feeds a shift-add multiplier (DW steps).
// Assumes: UNIT >= 1, go never coincides with clr, elem latched on clr.
module tcl_est #(
    parameter int DW   = 32,
    parameter int UNIT = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [DW-1:0] elem_in,
    input  logic          go,
    input  logic [DW-1:0] unit_time,
    output logic          est_valid,
    output logic [2*DW-1:0] est_cycles
);
    import tcl_pkg::*;

    localparam int TW = $clog2(DW);
    localparam logic [DW:0] UNIT_W = (DW+1)'(UNIT);

    est_state_t      st;
    logic [DW-1:0]   elem_q, quo, rem, mplier;
    logic [2*DW-1:0] mcand, acc;
    logic [TW-1:0]   step;
    logic [DW:0]     rem_sh, rem_dif;
    logic            fits;

    // Divider datapath: shift in next dividend bit and trial-subtract
    always_comb begin
        rem_sh  = {rem, quo[DW-1]};
        rem_dif = rem_sh - UNIT_W;
        fits    = (rem_sh >= UNIT_W);
    end

    // Divide, round up, then multiply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= E_IDLE; elem_q <= '0; quo <= '0; rem <= '0; mplier <= '0;
            mcand <= '0; acc <= '0; step <= '0; est_valid <= 1'b0;
        end else if (clr) begin
            st <= E_IDLE; elem_q <= elem_in; est_valid <= 1'b0;
        end else begin
            case (st)
                E_IDLE: if (go) begin
                    quo <= elem_q; rem <= '0; step <= '0; est_valid <= 1'b0;
                    mcand <= {{DW{1'b0}}, unit_time}; st <= E_DIV;
                end
                E_DIV: begin
                    rem  <= fits ? rem_dif[DW-1:0] : rem_sh[DW-1:0];
                    quo  <= {quo[DW-2:0], fits};
                    step <= step + 1'b1;
                    if (step == TW'(DW-1)) st <= E_FIX;
                end
                E_FIX: begin
                    mplier <= quo + DW'(rem != '0);
                    acc <= '0; step <= '0; st <= E_MUL;
                end
                E_MUL: begin
                    if (mplier[0]) acc <= acc + mcand;
                    mcand  <= mcand << 1;
                    mplier <= mplier >> 1;
                    step   <= step + 1'b1;
                    if (step == TW'(DW-1)) begin
                        est_valid <= 1'b1; st <= E_IDLE;
                    end
                end
                default: st <= E_IDLE;
            endcase
        end
    end

    assign est_cycles = acc;
endmodule

// File: rtl/tcl_pbank.sv
// Parameter slot bank: holds width, exchange index and fetched value per slot.
// Assumes: writes addressed by slot number; bank cleared on an accepted start.
module tcl_pbank #(
    parameter int DW   = 32,
    parameter int MAXP = 8,
    parameter int SW   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              pair_we,
    input  logic [SW-1:0]     pair_sel,
    input  logic [15:0]       pair_word,
    input  logic              val_we,
    input  logic [SW-1:0]     val_sel,
    input  logic [DW-1:0]     val_data,
    input  logic [SW-1:0]     rd_sel,
    output logic [7:0]        rd_idx,
    output logic [8*MAXP-1:0] prm_width,
    output logic [DW*MAXP-1:0] prm_value
);
    logic [7:0] idx_a [MAXP];

    for (genvar k = 0; k < MAXP; k++) begin : g_slot
        logic [7:0]    wid_q, idx_q;
        logic [DW-1:0] val_q;

        // Slot k descriptor and value registers
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                wid_q <= '0; idx_q <= '0; val_q <= '0;
            end else begin
                if (pair_we && pair_sel == SW'(k)) begin
                    wid_q <= pair_word[15:8];
                    idx_q <= pair_word[7:0];
                end
                if (val_we && val_sel == SW'(k)) val_q <= val_data;
            end
        end

        assign idx_a[k] = idx_q;
        assign prm_width[8*k +: 8]  = wid_q;
        assign prm_value[DW*k +: DW] = val_q;
    end

    assign rd_idx = idx_a[rd_sel];
endmodule

// File: rtl/tcl_seq.sv
// Record walker: issues one memory read at a time, decodes each word by phase,
// streams configuration words with valid/ready and gathers exchange values.
// Assumes: memory returns data exactly one cycle after mem_rd_en.
module tcl_seq #(
    parameter int AW   = 8,
    parameter int DW   = 32,
    parameter int MAXP = 8,
    parameter int SW   = 3,
    parameter int CNW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [AW-1:0]  base_addr,
    output logic           mem_rd_en,
    output logic [AW-1:0]  mem_addr,
    input  logic [DW-1:0]  mem_rdata,
    input  logic [DW-1:0]  xreg_data,
    output logic           cfg_valid,
    input  logic           cfg_ready,
    output logic [DW-1:0]  cfg_data,
    output logic           cfg_param,
    output logic           busy,
    output logic           done,
    output logic           err,
    output logic [DW-1:0]  desc_param_ptr,
    output logic [15:0]    desc_width,
    output logic [15:0]    desc_height,
    output logic [DW-1:0]  desc_unit_time,
    output logic           desc_micro,
    output logic [CNW-1:0] prm_count,
    output logic           est_go,
    output logic           est_clr,
    output logic           pair_we,
    output logic           val_we,
    output logic [SW-1:0]  slot,
    output logic [15:0]    pair_word,
    output logic [DW-1:0]  val_data
);
    import tcl_pkg::*;

    ld_state_t     state;
    ld_phase_t     phase;
    logic [AW-1:0] addr;
    logic [DW-1:0] cnt, data_q;

    // Main walker: field decode, stream bound and parameter gathering
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE; phase <= P_LEN; addr <= '0; cnt <= '0;
            data_q <= '0; err <= 1'b0; desc_param_ptr <= '0;
            desc_width <= '0; desc_height <= '0; desc_unit_time <= '0;
            desc_micro <= 1'b0; prm_count <= '0; slot <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    addr <= base_addr; phase <= P_LEN; err <= 1'b0;
                    prm_count <= '0; desc_micro <= 1'b0; state <= S_RD;
                end
                S_RD: state <= S_WT;
                S_WT: begin
                    addr <= addr + 1'b1;
                    state <= S_RD;
                    case (phase)
                        P_LEN: if (mem_rdata == '0) begin
                            err <= 1'b1; state <= S_DONE;
                        end else begin
                            cnt <= mem_rdata; phase <= P_PTR;
                        end
                        P_PTR: begin desc_param_ptr <= mem_rdata; phase <= P_SIZE; end
                        P_SIZE: begin
                            desc_width  <= mem_rdata[15:0];
                            desc_height <= mem_rdata[31:16];
                            phase <= P_TIME;
                        end
                        P_TIME: begin desc_unit_time <= mem_rdata; phase <= P_KIND; end
                        P_KIND: begin desc_micro <= mem_rdata[0]; phase <= P_CFG; end
                        P_CFG, P_PCFG: begin data_q <= mem_rdata; state <= S_SEND; end
                        P_NUM: if (mem_rdata > DW'(MAXP)) begin
                            err <= 1'b1; state <= S_DONE;
                        end else if (mem_rdata == '0) begin
                            phase <= P_PLEN;
                        end else begin
                            prm_count <= mem_rdata[CNW-1:0]; cnt <= mem_rdata;
                            slot <= '0; phase <= P_PAIR;
                        end
                        P_PAIR: begin
                            cnt <= cnt - 1'b1;
                            if (cnt == DW'(1)) begin
                                slot <= '0; state <= S_GATH;
                            end else begin
                                slot <= slot + 1'b1;
                            end
                        end
                        P_PLEN: if (mem_rdata == '0) begin
                            state <= S_DONE;
                        end else begin
                            cnt <= mem_rdata; phase <= P_PCFG;
                        end
                        default: state <= S_DONE;
                    endcase
                end
                S_SEND: if (cfg_ready) begin
                    cnt <= cnt - 1'b1;
                    if (cnt != DW'(1))                state <= S_RD;
                    else if (phase == P_CFG && desc_micro) begin
                        phase <= P_NUM; state <= S_RD;
                    end else                          state <= S_DONE;
                end
                S_GATH: begin
                    slot <= slot + 1'b1;
                    if (CNW'(slot) == prm_count - CNW'(1)) begin
                        phase <= P_PLEN; state <= S_RD;
                    end
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Decoded strobes and stream outputs
    always_comb begin
        mem_rd_en = (state == S_RD);
        mem_addr  = addr;
        cfg_valid = (state == S_SEND);
        cfg_data  = data_q;
        cfg_param = (phase == P_PCFG);
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
        est_go    = (state == S_WT) && (phase == P_TIME);
        est_clr   = (state == S_IDLE) && start;
        pair_we   = (state == S_WT) && (phase == P_PAIR);
        pair_word = mem_rdata[15:0];
        val_we    = (state == S_GATH);
        val_data  = xreg_data;
    end
endmodule

// File: rtl/tcl_loader.sv
// Top: task configuration record loader. Ties the walker, parameter bank
// and run-time estimator together.
// Assumes: 1-cycle read-latency memory, combinational exchange-register read.
module tcl_loader #(
    parameter int AW   = 8,
    parameter int DW   = 32,
    parameter int MAXP = 8,
    parameter int UNIT = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [AW-1:0]       base_addr,
    input  logic [DW-1:0]       elem_count,
    output logic                mem_rd_en,
    output logic [AW-1:0]       mem_addr,
    input  logic [DW-1:0]       mem_rdata,
    output logic [7:0]          xreg_sel,
    input  logic [DW-1:0]       xreg_data,
    output logic                cfg_valid,
    input  logic                cfg_ready,
    output logic [DW-1:0]       cfg_data,
    output logic                cfg_param,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [DW-1:0]       desc_param_ptr,
    output logic [15:0]         desc_width,
    output logic [15:0]         desc_height,
    output logic [DW-1:0]       desc_unit_time,
    output logic                desc_micro,
    output logic [$clog2(MAXP+1)-1:0] prm_count,
    output logic [8*MAXP-1:0]   prm_width,
    output logic [DW*MAXP-1:0]  prm_value,
    output logic                est_valid,
    output logic [2*DW-1:0]     est_cycles
);
    localparam int SW  = (MAXP > 1) ? $clog2(MAXP) : 1;
    localparam int CNW = $clog2(MAXP+1);

    logic          est_go, est_clr, pair_we, val_we;
    logic [SW-1:0] slot;
    logic [15:0]   pair_word;
    logic [DW-1:0] val_data;

    tcl_seq #(.AW(AW), .DW(DW), .MAXP(MAXP), .SW(SW), .CNW(CNW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .xreg_data(xreg_data), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
        .cfg_data(cfg_data), .cfg_param(cfg_param), .busy(busy), .done(done),
        .err(err), .desc_param_ptr(desc_param_ptr), .desc_width(desc_width),
        .desc_height(desc_height), .desc_unit_time(desc_unit_time),
        .desc_micro(desc_micro), .prm_count(prm_count), .est_go(est_go),
        .est_clr(est_clr), .pair_we(pair_we), .val_we(val_we), .slot(slot),
        .pair_word(pair_word), .val_data(val_data)
    );

    tcl_pbank #(.DW(DW), .MAXP(MAXP), .SW(SW)) u_bank (
        .clk(clk), .rst_n(rst_n), .clr(est_clr),
        .pair_we(pair_we), .pair_sel(slot), .pair_word(pair_word),
        .val_we(val_we), .val_sel(slot), .val_data(val_data),
        .rd_sel(slot), .rd_idx(xreg_sel),
        .prm_width(prm_width), .prm_value(prm_value)
    );

    tcl_est #(.DW(DW), .UNIT(UNIT)) u_est (
        .clk(clk), .rst_n(rst_n), .clr(est_clr), .elem_in(elem_count),
        .go(est_go), .unit_time(mem_rdata),
        .est_valid(est_valid), .est_cycles(est_cycles)
    );
endmodule

// File: rtl/tcl_loader_chk.sv
// Property checker for tcl_loader, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module tcl_loader_chk #(
    parameter int DW   = 32,
    parameter int MAXP = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          mem_rd_en,
    input logic          cfg_valid,
    input logic          cfg_ready,
    input logic [DW-1:0] cfg_data,
    input logic          cfg_param,
    input logic          done,
    input logic          err,
    input logic          desc_micro,
    input logic [$clog2(MAXP+1)-1:0] prm_count
);
    // R3: a stalled word is held
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_data));

    // R11: done never lasts two cycles
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: an idle block neither reads nor streams
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cfg_valid && !mem_rd_en);

    // R4 / R7: an error appears together with the done pulse
    p_err_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    // R6: captured count bounded
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prm_count <= MAXP);

    // R8: parameterized words only for specialized records
    p_pcfg_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_param |-> desc_micro);

    // R10: start while busy does not return the block to idle
    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !done |=> busy);
endmodule

bind tcl_loader tcl_loader_chk #(.DW(DW), .MAXP(MAXP)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .mem_rd_en(mem_rd_en), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_data(cfg_data), .cfg_param(cfg_param), .done(done), .err(err),
    .desc_micro(desc_micro), .prm_count(prm_count)
);

// File: tb/tcl_loader_test.sv
// Bench for tcl_loader: a vector table of records walked by one loop,
// then directed reset and restart checks.
module tcl_loader_test;
    localparam int CLK_NS = 10;
    localparam int AW = 8, DW = 32, MAXP = 8, UNIT = 100;

    typedef struct packed {
        logic [7:0]  base;
        logic [7:0]  len;
        logic        micro;
        logic [7:0]  n;
        logic [7:0]  plen;
        logic [31:0] elem;
        logic [31:0] utime;
        logic [7:0]  rdy;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'd0,   8'd3, 1'b0, 8'd0, 8'd0, 32'd100, 32'd1415, 8'hFF},
        '{8'd30,  8'd4, 1'b0, 8'd0, 8'd0, 32'd101, 32'd1415, 8'h69},
        '{8'd60,  8'd2, 1'b1, 8'd3, 8'd2, 32'd250, 32'd7,    8'hFF},
        '{8'd90,  8'd1, 1'b1, 8'd8, 8'd3, 32'd1,   32'd9,    8'hB3},
        '{8'd120, 8'd2, 1'b1, 8'd0, 8'd1, 32'd0,   32'd5,    8'hFF},
        '{8'd150, 8'd0, 1'b0, 8'd0, 8'd0, 32'd50,  32'd3,    8'hFF},
        '{8'd180, 8'd1, 1'b1, 8'd9, 8'd2, 32'd10,  32'd4,    8'hFF}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [AW-1:0] base_addr = '0, mem_addr;
    logic [DW-1:0] elem_count = '0, mem_rdata, xreg_data, cfg_data;
    logic [DW-1:0] desc_param_ptr, desc_unit_time;
    logic [7:0] xreg_sel;
    logic mem_rd_en, cfg_valid, cfg_ready, cfg_param, busy, done, err;
    logic desc_micro, est_valid;
    logic [15:0] desc_width, desc_height;
    logic [3:0] prm_count;
    logic [8*MAXP-1:0] prm_width;
    logic [DW*MAXP-1:0] prm_value, snap;
    logic [2*DW-1:0] est_cycles;

    logic [DW-1:0] mem [256];
    logic [DW-1:0] cfg_got [16], pcfg_got [16];
    int ncfg, npc, ndone, max_rd, cyc, nchk, nfail;
    logic [7:0] rdy_pat = 8'hFF;

    tcl_loader #(.AW(AW), .DW(DW), .MAXP(MAXP), .UNIT(UNIT)) uut (.*);

    always #(CLK_NS/2) clk = ~clk;

    // Memory model with one-cycle read latency
    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];
    assign xreg_data = 32'h1000_0000 + 32'(xreg_sel) * 32'h111;

    // Monitor: drive ready, record transfers, done pulses and read extent
    always @(negedge clk) begin
        cyc = cyc + 1;
        cfg_ready = rdy_pat[cyc % 8];
        if (cfg_valid && cfg_ready) begin
            if (!cfg_param) begin
                if (ncfg < 16) cfg_got[ncfg] = cfg_data;
                ncfg = ncfg + 1;
            end else begin
                if (npc == 0) snap = prm_value;
                if (npc < 16) pcfg_got[npc] = cfg_data;
                npc = npc + 1;
            end
        end
        if (done) ndone = ndone + 1;
        if (mem_rd_en && int'(mem_addr) > max_rd) max_rd = int'(mem_addr);
    end

    // Watchdog
    initial begin
        #(CLK_NS * 150000);
        nfail = nfail + 1;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nfail = nfail + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] xval(input int idx);
        return 32'h1000_0000 + 32'(idx) * 32'h111;
    endfunction

    task automatic load_rec(input vec_t v, input int vi);
        int a;
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
        mem[v.base]     = 32'(v.len);
        mem[v.base + 1] = 32'h8000_0000 | 32'(vi);
        mem[v.base + 2] = {16'(vi + 2), 16'(vi + 10)};
        mem[v.base + 3] = v.utime;
        mem[v.base + 4] = {31'h0, v.micro};
        for (int i = 0; i < int'(v.len); i++)
            mem[v.base + 5 + i] = 32'hA500_0000 | (32'(vi) << 8) | 32'(i);
        a = int'(v.base) + 5 + int'(v.len);
        mem[a] = 32'(v.n);
        for (int k = 0; k < int'(v.n); k++)
            mem[a + 1 + k] = {16'h0, 8'(k + 4), 8'((k * 3 + vi) % 16)};
        mem[a + 1 + int'(v.n)] = 32'(v.plen);
        for (int j = 0; j < int'(v.plen); j++)
            mem[a + 2 + int'(v.n) + j] = 32'h5A00_0000 | (32'(vi) << 8) | 32'(j);
    endtask

    task automatic run_vec(input vec_t v, input int vi, input bit restart);
        bit exp_err;
        int last, t;
        load_rec(v, vi);
        mem[200] = 32'd5;
        ncfg = 0; npc = 0; ndone = 0; max_rd = -1; snap = '0;
        rdy_pat = v.rdy;
        @(negedge clk); start = 1'b1; base_addr = v.base; elem_count = v.elem;
        @(negedge clk); start = 1'b0;
        if (restart) begin
            repeat (3) @(negedge clk);
            start = 1'b1; base_addr = 8'd200; elem_count = 32'd999;
            @(negedge clk); start = 1'b0;
        end
        t = 0;
        while (ndone == 0 && t < 2000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);

        exp_err = (v.len == 0) || (v.micro && v.n > 8);
        chk($sformatf("R4/R7 v%0d err", vi), 64'(err), 64'(exp_err));
        chk($sformatf("R11 v%0d done pulses", vi), 64'(ndone), 64'd1);
        chk($sformatf("R3 v%0d cfg word count", vi), 64'(ncfg), 64'(v.len));
        for (int i = 0; i < int'(v.len) && i < 16; i++)
            chk($sformatf("R3 v%0d cfg word %0d", vi, i), 64'(cfg_got[i]),
                64'(32'hA500_0000 | (32'(vi) << 8) | 32'(i)));
        if (v.len == 0)                 last = v.base;
        else if (!v.micro)              last = v.base + 4 + v.len;
        else if (v.n > 8)               last = v.base + 5 + v.len;
        else                            last = v.base + 6 + v.len + v.n + v.plen;
        chk($sformatf("R5/R6 v%0d last read addr", vi), 64'(max_rd), 64'(last));
        if (!exp_err) begin
            chk($sformatf("R2 v%0d ptr", vi), 64'(desc_param_ptr), 64'(32'h8000_0000 | 32'(vi)));
            chk($sformatf("R2 v%0d width", vi), 64'(desc_width), 64'(vi + 10));
            chk($sformatf("R2 v%0d height", vi), 64'(desc_height), 64'(vi + 2));
            chk($sformatf("R2 v%0d utime", vi), 64'(desc_unit_time), 64'(v.utime));
            chk($sformatf("R2 v%0d kind", vi), 64'(desc_micro), 64'(v.micro));
        end
        if (v.micro && !exp_err) begin
            chk($sformatf("R6 v%0d count", vi), 64'(prm_count), 64'(v.n));
            for (int k = 0; k < int'(v.n); k++) begin
                chk($sformatf("R6 v%0d width %0d", vi, k), 64'(prm_width[8*k +: 8]), 64'(k + 4));
                chk($sformatf("R6 v%0d value %0d", vi, k), 64'(prm_value[32*k +: 32]),
                    64'(xval((k * 3 + vi) % 16)));
            end
            chk($sformatf("R8 v%0d pcfg count", vi), 64'(npc), 64'(v.plen));
            for (int j = 0; j < int'(v.plen); j++)
                chk($sformatf("R8 v%0d pcfg word %0d", vi, j), 64'(pcfg_got[j]),
                    64'(32'h5A00_0000 | (32'(vi) << 8) | 32'(j)));
            if (v.plen > 0)
                chk($sformatf("R8 v%0d params before first pcfg", vi), 64'(snap == prm_value), 64'd1);
        end
        if (v.micro && v.n > 8) begin
            chk($sformatf("R7 v%0d no params", vi), 64'(prm_count), 64'd0);
            chk($sformatf("R7 v%0d no pcfg", vi), 64'(npc), 64'd0);
        end
        if (v.len == 0)
            chk($sformatf("R4 v%0d no estimate", vi), 64'(est_valid), 64'd0);
        if (!exp_err) begin
            t = 0;
            while (!est_valid && t < 300) begin @(negedge clk); t++; end
            chk($sformatf("R9 v%0d est_valid", vi), 64'(est_valid), 64'd1);
            chk($sformatf("R9 v%0d est_cycles", vi), est_cycles,
                64'(v.utime) * ((64'(v.elem) + 64'(UNIT) - 1) / 64'(UNIT)));
        end
    endtask

    initial begin
        cyc = 0; nchk = 0; nfail = 0; cfg_ready = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 err", 64'(err), 64'd0);
        chk("R1 cfg_valid", 64'(cfg_valid), 64'd0);
        chk("R1 mem_rd_en", 64'(mem_rd_en), 64'd0);
        chk("R1 est_valid", 64'(est_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", 64'(busy), 64'd0);

        for (int vi = 0; vi < NV; vi++) run_vec(VECS[vi], vi, 1'b0);

        // R10: second start mid-load must be ignored
        run_vec(VECS[2], 2, 1'b1);
        run_vec(VECS[1], 1, 1'b1);

        // R1: reset in mid-load returns to idle
        load_rec(VECS[0], 0);
        @(negedge clk); start = 1'b1; base_addr = 8'd0;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after mid-load reset", 64'(busy), 64'd0);
        chk("R1 cfg_valid after mid-load reset", 64'(cfg_valid), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule